// File: doc/BRIEF.md
# Framed Register Access Command Decoder

This block turns a byte stream from a configuration channel into read and write operations on an internal register file. Each frame opens with a header byte, and that byte fixes both the frame type and its length. A write frame is four bytes long: header, bank selector, register address and data. It changes one register and returns nothing. A read frame is three bytes long: header, bank selector and address. It returns exactly one byte, which holds the addressed register's contents, on the output byte stream.

Both byte streams use valid/ready handshakes. While a read reply waits to be taken, the parser holds its input off. Outside the frame interface, the rest of the chip reads the configuration contents through a combinational register-file port. Any byte that arrives while the parser waits for a header, and is not a header, is dropped.

Top module: `cfg_frame_decoder`

## Requirements
- R1: After reset the parser waits for a header, `in_ready` is 1, `out_valid` is 0, and every register in every bank reads 0 on the register-file port.
- R2: A write frame is the byte sequence 0x5A, bank, address, data. It stores data at that bank and address. On the register-file port the old value still shows in the cycle after the data byte is accepted, and the new value shows from the following cycle on.
- R3: A write frame never raises `out_valid`.
- R4: A read frame is the byte sequence 0x55, bank, address. In the cycle after the address byte is accepted, `out_valid` is 1 and `out_data` holds the register's current value.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` does not change and `in_ready` stays 0. The cycle after `out_ready` is seen, `out_valid` is 0 and `in_ready` is 1.
- R6: While the parser waits for a header, a byte other than 0x55 or 0x5A is accepted and discarded. It changes no register, produces no reply, and leaves the parser waiting for a header.
- R7: The bank is taken from the low log2(NUM_BANKS) bits of the bank selector byte. With the default of two banks, bit 0 of that byte selects the bank, so 0x32 selects bank 0 and 0x33 selects bank 1. Each bank holds 256 independent 8-bit registers.
- R8: Frames may follow one another with no idle cycles between them, including a write frame directly followed by another write frame, and every frame takes effect.
- R9: Inside a frame body, the byte values 0x55 and 0x5A are ordinary bank, address or data values. They do not restart the frame.
- R10: Cycles in which `in_valid` is 0 partway through a frame do not change the frame's position or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | Incoming byte is present |
| in_ready | output | 1 | Parser can accept a byte |
| out_data | output | 8 | Read reply byte |
| out_valid | output | 1 | Reply byte is present |
| out_ready | input | 1 | Consumer takes the reply byte |
| cfg_bank | input | log2(NUM_BANKS) | Bank index for the register-file port |
| cfg_addr | input | 8 | Register index for the register-file port |
| cfg_data | output | 8 | Contents of the selected register |

## Verification
On every cycle, the assertions check the reply handshake: the reply byte stays stable and input stays stalled until the reply is taken. They also check that a read address always yields a reply, that a write data byte never does, and that a non-header byte in the header-wait state leaves the parser idle with no reply. Whether the right value lands in the right bank and address, and whether a read returns what was written, can only be shown by the bench. It writes and then reads back every register of both banks. It also covers frames with idle gaps, frames sent back to back, header values used as body bytes, and the exact cycle in which a write becomes visible.

// File: rtl/cfg_frame_decoder.sv
module cfg_frame_decoder #(
  parameter int NUM_BANKS = 2,
  parameter logic [7:0] HDR_RD = 8'h55,
  parameter logic [7:0] HDR_WR = 8'h5A
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [7:0]           out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] cfg_bank,
  input  logic [7:0]           cfg_addr,
  output logic [7:0]           cfg_data
);
  localparam int BW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int AW      = 8;
  localparam int IW      = BW + AW;
  localparam int ENTRIES = (1 << BW) << AW;

  typedef enum logic [2:0] {S_IDLE, S_BANK, S_ADDR, S_DATA, S_RESP} st_t;

  st_t             st;
  logic            is_rd;
  logic [BW-1:0]   bank_q;
  logic [AW-1:0]   addr_q;
  logic            wr_pend;
  logic [IW-1:0]   wr_idx;
  logic [7:0]      wr_val;
  logic [7:0]      regs [ENTRIES];

  wire fire   = in_valid && in_ready;
  wire is_hdr = (in_data == HDR_RD) || (in_data == HDR_WR);

  assign in_ready  = (st != S_RESP);
  assign out_valid = (st == S_RESP);
  assign cfg_data  = regs[{cfg_bank, cfg_addr}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) regs[i] <= '0;
    end else if (wr_pend) begin
      regs[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      is_rd    <= 1'b0;
      bank_q   <= '0;
      addr_q   <= '0;
      wr_pend  <= 1'b0;
      wr_idx   <= '0;
      wr_val   <= '0;
      out_data <= '0;
    end else begin
      wr_pend <= (st == S_DATA) && fire;
      case (st)
        S_IDLE: if (fire && is_hdr) begin
          is_rd <= (in_data == HDR_RD);
          st    <= S_BANK;
        end
        S_BANK: if (fire) begin
          bank_q <= in_data[BW-1:0];
          st     <= S_ADDR;
        end
        S_ADDR: if (fire) begin
          if (is_rd) begin
            out_data <= regs[{bank_q, in_data}];
            st       <= S_RESP;
          end else begin
            addr_q <= in_data;
            st     <= S_DATA;
          end
        end
        S_DATA: if (fire) begin
          wr_idx <= {bank_q, addr_q};
          wr_val <= in_data;
          st     <= S_IDLE;
        end
        S_RESP: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
  AST_STALL_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !in_ready); // R5
  AST_RELEASE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R5
  AST_READ_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && is_rd && fire) |=> out_valid); // R4
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && fire) |=> !out_valid); // R3
  AST_JUNK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && fire && !is_hdr) |=> (st == S_IDLE && !out_valid && !wr_pend)); // R6
endmodule

// File: tb/cfg_frame_decoder_tb_top.sv
module cfg_frame_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [7:0] out_data, cfg_data, cfg_addr = 0;
  logic [0:0] cfg_bank = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_frame_decoder #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .cfg_bank(cfg_bank), .cfg_addr(cfg_addr), .cfg_data(cfg_data));

  function automatic logic [7:0] pat(int b, int a);
    return 8'((a * 7 + b * 91 + 1) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(logic [7:0] b);
    in_data = b; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic peek(int b, int a, output logic [7:0] v);
    cfg_bank = 1'(b); cfg_addr = 8'(a); #1 v = cfg_data;
  endtask

  task automatic wr(logic [7:0] bsel, logic [7:0] a, logic [7:0] d);
    send(8'h5A); send(bsel); send(a); send(d);
  endtask

  task automatic rd(logic [7:0] bsel, logic [7:0] a, int hold, int exp, string req);
    send(8'h55); send(bsel); send(a);
    chk("R4 valid", int'(out_valid), 1);
    chk(req, int'(out_data), exp);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R5 hold valid", int'(out_valid), 1);
      chk("R5 hold data", int'(out_data), exp);
      chk("R5 stall", int'(in_ready), 0);
    end
    out_ready = 1; @(negedge clk); out_ready = 0;
    chk("R5 release valid", int'(out_valid), 0);
    chk("R5 release ready", int'(in_ready), 1);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 256; a++) begin peek(b, a, v); chk("R1 zero", int'(v), 0); end

    // R2 timing of write visibility
    cfg_bank = 1; cfg_addr = 8'h10;
    send(8'h5A); send(8'h33); send(8'h10); send(8'hC3);
    #1 chk("R2 old value next cycle", int'(cfg_data), 0);
    chk("R3 no reply", int'(out_valid), 0);
    @(negedge clk); #1 chk("R2 new value", int'(cfg_data), 8'hC3);

    // R7 R8 sweep: back-to-back writes to every register of both banks
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 256; a++) begin
        wr(8'(8'h32 | b), 8'(a), pat(b, a));
        chk("R3 no reply", int'(out_valid), 0);
      end
    @(negedge clk);
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 256; a++) begin peek(b, a, v); chk("R7 R8 port", int'(v), int'(pat(b, a))); end
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < 256; a++) rd(8'(8'hF0 | b), 8'(a), a % 3, int'(pat(b, a)), "R4 R7 read");

    // R6 junk bytes in idle
    foreach (v[i]) ;
    send(8'h00); send(8'h32); send(8'hFF); send(8'h54); send(8'h5B); send(8'h10); send(8'h77);
    chk("R6 no reply", int'(out_valid), 0);
    chk("R6 ready", int'(in_ready), 1);
    @(negedge clk);
    peek(0, 8'h10, v); chk("R6 reg intact", int'(v), int'(pat(0, 16)));
    peek(0, 8'h77, v); chk("R6 reg intact", int'(v), int'(pat(0, 119)));
    rd(8'h00, 8'h32, 0, int'(pat(0, 50)), "R6 parser idle after junk");

    // R9 header values as body bytes
    wr(8'h55, 8'h5A, 8'h55);
    wr(8'h5A, 8'h55, 8'h5A);
    @(negedge clk);
    peek(1, 8'h5A, v); chk("R9 body 0x55", int'(v), 8'h55);
    peek(0, 8'h55, v); chk("R9 body 0x5A", int'(v), 8'h5A);
    rd(8'h55, 8'h5A, 2, 8'h55, "R9 read");

    // R10 gaps inside frames
    send(8'h5A); repeat (3) @(negedge clk);
    send(8'h01); @(negedge clk);
    send(8'hAB); repeat (5) @(negedge clk);
    send(8'h9D); @(negedge clk);
    peek(1, 8'hAB, v); chk("R10 gapped write", int'(v), 8'h9D);
    send(8'h55); repeat (2) @(negedge clk);
    send(8'h01); repeat (4) @(negedge clk);
    chk("R10 no early reply", int'(out_valid), 0);
    send(8'hAB);
    chk("R10 gapped read", int'(out_data), 8'h9D);
    out_ready = 1; @(negedge clk); out_ready = 0;

    // R1 reset again clears contents
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    peek(1, 8'hAB, v); chk("R1 cleared", int'(v), 0);
    chk("R1 out_valid", int'(out_valid), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule